// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit with Read-Clear

This block is the interrupt flag and vector logic of a serial peripheral. It keeps one pending flag per interrupt source: receive, transmit-holding-empty, start, and any further sources. Each flag has its own enable bit. A vector register reports a numeric code for the highest-priority source that is both pending and enabled, and a single request line tells the interrupt controller that such a source exists. Software reaches every register through a plain read/write port.

Reading the vector clears the flag it reports. Because of that side effect, the flag register also accepts masked software writes, so software can put back a flag it still needs. A classic case is a transmit-empty flag that was consumed on the last byte of a message. A hardware event that sets a flag is never lost: not to a software write in the same cycle, and not to a vector read in the same cycle.

The unit also contains the one-byte transmit holding buffer. The buffer hands its byte to the external shifter with a load strobe, and that hand-over sets the transmit flag again. A software reset bit holds the unit in a defined state until software releases it.

Top module: `irqv_unit`

## Requirements
- R1: After hard reset, the control register reads 0x01 (software reset bit 0 set). The flag register reads 0x02 (only the transmit flag). The enable register reads 0x00, the vector reads 0, and `irq` is low.
- R2: The vector register (address 3) reads 2*(i+1), where i is the lowest index among the flags that are both pending and enabled. It reads 0 when no flag qualifies. Flag indexes are: 0 receive, 1 transmit, 2 start, 3 and above auxiliary.
- R3: A read of the vector register clears only the flag it reported. All other flags keep their values.
- R4: When a vector read and a hardware set of the reported flag fall in the same cycle, the flag stays set.
- R5: A write to the flag register (address 2) changes only the bits selected by `reg_wmask`. A hardware set of any bit in the same cycle wins over that write, including a software clear of the same bit.
- R6: `irq` is high in exactly the cycles in which the vector register is nonzero. It follows the registered flags and enables with no added delay.
- R7: A write to the holding buffer (address 4) while the buffer is empty stores the byte and clears the transmit flag (bit 1).
- R8: While the buffer is full and `sh_ready` is high, `sh_load` is high for that cycle with the held byte on `sh_data`. The buffer then empties and the transmit flag is set, whatever the transmit enable holds.
- R9: A write to the holding buffer while it is full is ignored: the held byte is unchanged. Overrun, bit 0 of the status register (address 5), is set instead.
- R10: While the software reset bit is 1, several effects apply. The transmit flag is forced to 1. The receive flag and enable bits 1:0 are forced to 0. The status bits are cleared, the buffer is emptied, and hardware events and buffer writes are ignored. Other flags and enables keep their values.
- R11: `err_evt` sets status bit 1 and `brk_evt` sets status bit 2. A masked write to the status register changes only the selected bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (vector read side effect) |
| reg_addr | input | 3 | Register address: 0 control, 1 enable, 2 flags, 3 vector, 4 holding, 5 status |
| reg_wdata | input | DATA_W | Write data |
| reg_wmask | input | DATA_W | Per-bit write mask for flag and status writes |
| reg_rdata | output | DATA_W | Read data, combinational from address |
| rx_evt | input | 1 | Receive event strobe, sets flag 0 |
| aux_evt | input | NUM_SRC-2 | Start and other event strobes, set flags 2 and up |
| err_evt | input | 1 | Receive error strobe |
| brk_evt | input | 1 | Break detected strobe |
| sh_ready | input | 1 | Shifter can take a byte |
| sh_load | output | 1 | Holding byte moves to shifter this cycle |
| sh_data | output | DATA_W | Held byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of pending flags and enables for five sources. It checks the vector code, the request line and the flag left behind by each vector read. An inverted priority or an off-by-one code shows up as a wrong vector. A read that clears every flag shows up as lost neighbours. The same-cycle races are driven on purpose: a vector read against a receive event, and a masked software clear against a hardware set. An arbitration order that lets software win would drop the event. The holding buffer is overfilled to show the byte is kept and overrun is set. The bench also checks that the transmit flag comes back with the transmit enable off. Software reset is asserted with a byte held and events arriving, to show the forced values and that no load escapes.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
// Package: register addresses and fixed source indexes shared by the unit.
package irqv_pkg;
    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_ENABLE = 3'd1,
        RA_FLAGS  = 3'd2,
        RA_VECTOR = 3'd3,
        RA_TXHOLD = 3'd4,
        RA_STATUS = 3'd5
    } reg_addr_e;

    localparam int SRC_RX = 0;
    localparam int SRC_TX = 1;

    localparam int ST_OVR = 0;
    localparam int ST_ERR = 1;
    localparam int ST_BRK = 2;
    localparam int ST_W   = 3;
endpackage

// File: rtl/irqv_prio.sv
`timescale 1ns/1ps
// Module: irqv_prio
// Fixed-priority selector. The lowest request index wins. It gives a
// one-hot grant and the even vector code 2*(i+1), or zero with no request.
// Assumes N*2 fits in CODE_W bits.
module irqv_prio #(
    parameter int N      = 5,
    parameter int CODE_W = 8
) (
    input  logic [N-1:0]      req,
    output logic [N-1:0]      grant,
    output logic [CODE_W-1:0] code
);
    // Scan from index 0 upwards; the first request found is taken.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        code  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                code     = CODE_W'(2 * (i + 1));
            end
        end
    end
endmodule

// File: rtl/irqv_flags.sv
`timescale 1ns/1ps
// Module: irqv_flags
// Bank of pending flags. Each bit is arbitrated on its own in this order:
// read clear, masked software write, internal hardware clear, hardware
// set, and software reset forcing last. Assumes N > SRC_TX.
module irqv_flags
    import irqv_pkg::*;
#(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] hw_clr,
    input  logic [N-1:0] rd_clr,
    input  logic         sw_we,
    input  logic [N-1:0] sw_data,
    input  logic [N-1:0] sw_mask,
    output logic [N-1:0] flags
);
    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        localparam logic RST_VAL = (gi == SRC_TX);
        logic nxt;

        // Next value of one flag under the fixed arbitration order.
        always_comb begin
            nxt = flags[gi];
            if (rd_clr[gi])                nxt = 1'b0;
            if (sw_we && sw_mask[gi])      nxt = sw_data[gi];
            if (hw_clr[gi])                nxt = 1'b0;
            if (hw_set[gi] && !soft_rst)   nxt = 1'b1;
            if (soft_rst && gi == SRC_RX)  nxt = 1'b0;
            if (soft_rst && gi == SRC_TX)  nxt = 1'b1;
        end

        // Flag storage with its hard-reset value.
        always_ff @(posedge clk) begin
            if (!rst_n) flags[gi] <= RST_VAL;
            else        flags[gi] <= nxt;
        end
    end
endmodule

// File: rtl/irqv_txhold.sv
`timescale 1ns/1ps
// Module: irqv_txhold
// One-entry transmit holding buffer. It accepts a byte only while empty
// and hands the byte to the shifter when the shifter is ready. Software
// reset empties it and blocks both directions.
module irqv_txhold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         sh_ready,
    output logic         sh_load,
    output logic [W-1:0] sh_data,
    output logic         accepted,
    output logic         overrun,
    output logic         full
);
    assign accepted = wr_en && !full && !soft_rst;
    assign overrun  = wr_en &&  full && !soft_rst;
    assign sh_load  = full && sh_ready && !soft_rst;

    // Occupancy: set on accepted write, cleared on hand-over or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        full <= 1'b0;
        else if (soft_rst) full <= 1'b0;
        else if (accepted) full <= 1'b1;
        else if (sh_load)  full <= 1'b0;
    end

    // Byte storage, loaded only by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh_data <= '0;
        else if (accepted) sh_data <= wr_data;
    end
endmodule

// File: rtl/irqv_unit.sv
`timescale 1ns/1ps
// Module: irqv_unit (top)
// Interrupt flag, enable and vector unit with a transmit holding buffer.
// A vector read clears the reported flag. Masked flag writes never lose
// a same-cycle hardware set. Assumes 2 < NUM_SRC <= DATA_W and
// 2*NUM_SRC < 2**DATA_W.
module irqv_unit
    import irqv_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int DATA_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [2:0]           reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [DATA_W-1:0]    reg_wmask,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 rx_evt,
    input  logic [NUM_SRC-3:0]   aux_evt,
    input  logic                 err_evt,
    input  logic                 brk_evt,
    input  logic                 sh_ready,
    output logic                 sh_load,
    output logic [DATA_W-1:0]    sh_data,
    output logic                 irq
);
    localparam int CODE_W = DATA_W;

    reg_addr_e           addr;
    logic                swrst;
    logic [NUM_SRC-1:0]  en;
    logic [NUM_SRC-1:0]  flags;
    logic [NUM_SRC-1:0]  req;
    logic [NUM_SRC-1:0]  grant;
    logic [CODE_W-1:0]   vec_code;
    logic [NUM_SRC-1:0]  hw_set;
    logic [NUM_SRC-1:0]  hw_clr;
    logic [NUM_SRC-1:0]  rd_clr;
    logic [ST_W-1:0]     stat;
    logic [ST_W-1:0]     stat_set;
    logic                hold_acc;
    logic                hold_ovr;
    logic                hold_full;
    logic                wr_ctrl, wr_en_reg, wr_flags, wr_hold, wr_stat, rd_vec;

    assign addr      = reg_addr_e'(reg_addr);
    assign wr_ctrl   = reg_wr && addr == RA_CTRL;
    assign wr_en_reg = reg_wr && addr == RA_ENABLE;
    assign wr_flags  = reg_wr && addr == RA_FLAGS;
    assign wr_hold   = reg_wr && addr == RA_TXHOLD;
    assign wr_stat   = reg_wr && addr == RA_STATUS;
    assign rd_vec    = reg_rd && addr == RA_VECTOR;

    assign hw_set = {aux_evt, sh_load, rx_evt};
    assign hw_clr = NUM_SRC'(hold_acc) << SRC_TX;
    assign rd_clr = rd_vec ? grant : '0;
    assign req    = flags & en;
    assign irq    = |req;

    // Software reset bit: comes up set after hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       swrst <= 1'b1;
        else if (wr_ctrl) swrst <= reg_wdata[0];
    end

    // Enable register; receive and transmit enables forced off in soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else begin
            if (wr_en_reg) en <= reg_wdata[NUM_SRC-1:0];
            if (swrst)     en[SRC_TX:SRC_RX] <= 2'b00;
        end
    end

    irqv_flags #(.N(NUM_SRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (swrst),
        .hw_set   (hw_set),
        .hw_clr   (hw_clr),
        .rd_clr   (rd_clr),
        .sw_we    (wr_flags),
        .sw_data  (reg_wdata[NUM_SRC-1:0]),
        .sw_mask  (reg_wmask[NUM_SRC-1:0]),
        .flags    (flags)
    );

    irqv_prio #(.N(NUM_SRC), .CODE_W(CODE_W)) u_prio (
        .req   (req),
        .grant (grant),
        .code  (vec_code)
    );

    irqv_txhold #(.W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (swrst),
        .wr_en    (wr_hold),
        .wr_data  (reg_wdata),
        .sh_ready (sh_ready),
        .sh_load  (sh_load),
        .sh_data  (sh_data),
        .accepted (hold_acc),
        .overrun  (hold_ovr),
        .full     (hold_full)
    );

    assign stat_set = {brk_evt, err_evt, hold_ovr};

    // Status bits: masked write, then hardware set, then soft reset clear.
    for (genvar gs = 0; gs < ST_W; gs++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat[gs] <= 1'b0;
            end else if (swrst) begin
                stat[gs] <= 1'b0;
            end else if (stat_set[gs]) begin
                stat[gs] <= 1'b1;
            end else if (wr_stat && reg_wmask[gs]) begin
                stat[gs] <= reg_wdata[gs];
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (addr)
            RA_CTRL:   reg_rdata = DATA_W'(swrst);
            RA_ENABLE: reg_rdata = DATA_W'(en);
            RA_FLAGS:  reg_rdata = DATA_W'(flags);
            RA_VECTOR: reg_rdata = vec_code;
            RA_STATUS: reg_rdata = DATA_W'(stat);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqv_unit_chk.sv
`timescale 1ns/1ps
// Module: irqv_unit_chk
// Property checker bound into irqv_unit. It watches the ports and the
// internal flag, enable and buffer state.
module irqv_unit_chk #(
    parameter int NUM_SRC = 5,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               swrst,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [2:0]         reg_addr,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] hw_set,
    input logic [DATA_W-1:0]  vec_code,
    input logic               irq,
    input logic               sh_load,
    input logic               hold_full,
    input logic [2:0]         stat
);
    logic [DATA_W-1:0]  idx;
    logic [NUM_SRC-1:0] rep_mask;
    logic               vec_rd, flag_wr;

    assign idx      = (vec_code >> 1) - DATA_W'(1);
    assign rep_mask = (vec_code != '0) ? (NUM_SRC'(1) << idx) : '0;
    assign vec_rd   = reg_rd && reg_addr == 3'd3 && vec_code != '0;
    assign flag_wr  = reg_wr && reg_addr == 3'd2;

    assert_irq_vec_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (vec_code != '0));

    assert_vec_code_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_code[0] && vec_code <= DATA_W'(2 * NUM_SRC));

    assert_vec_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !flag_wr && !swrst && (hw_set & rep_mask) == '0)
        |=> (flags & $past(rep_mask)) == '0);

    assert_vec_read_race_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !swrst && (hw_set & rep_mask) != '0)
        |=> (flags & $past(rep_mask)) != '0);

    assert_hw_set_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !swrst |=> (flags & $past(hw_set)) == $past(hw_set));

    assert_load_sets_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sh_load |=> flags[1]);

    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4 && hold_full && !swrst) |=> stat[0]);

    assert_soft_reset_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (flags[1] && !flags[0] && en[1:0] == 2'b00 && !hold_full
                   && !sh_load && stat == 3'b000));
endmodule

bind irqv_unit irqv_unit_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .swrst     (swrst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .flags     (flags),
    .en        (en),
    .hw_set    (hw_set),
    .vec_code  (vec_code),
    .irq       (irq),
    .sh_load   (sh_load),
    .hold_full (hold_full),
    .stat      (stat)
);

// File: tb/irqv_unit_bench.sv
`timescale 1ns/1ps
// Bench: sweeps all flag/enable patterns for five sources and drives the
// same-cycle races, buffer corner cases and software reset.
module irqv_unit_bench;
    localparam int NS = 5;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0, reg_wmask = '0;
    logic [DW-1:0] reg_rdata;
    logic          rx_evt = 1'b0;
    logic [NS-3:0] aux_evt = '0;
    logic          err_evt = 1'b0, brk_evt = 1'b0, sh_ready = 1'b0;
    logic          sh_load;
    logic [DW-1:0] sh_data;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irqv_unit #(.NUM_SRC(NS), .DATA_W(DW)) u_irqv_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
        .reg_rdata(reg_rdata), .rx_evt(rx_evt), .aux_evt(aux_evt),
        .err_evt(err_evt), .brk_evt(brk_evt), .sh_ready(sh_ready),
        .sh_load(sh_load), .sh_data(sh_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Each task starts right after a falling edge and ends at the next one.
    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [7:0] m);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
        @(negedge clk);
        reg_wr = 1'b0; reg_wmask = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [7:0] exp_vec(input int m);
        for (int i = 0; i < NS; i++)
            if (m[i]) return 8'(2 * (i + 1));
        return 8'd0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: hard reset state
        chk("R1 irq", 32'(irq), 0);
        rd(3'd0, d); chk("R1 ctrl", 32'(d), 32'h01);
        rd(3'd2, d); chk("R1 flags", 32'(d), 32'h02);
        rd(3'd1, d); chk("R1 enable", 32'(d), 32'h00);
        rd(3'd3, d); chk("R1 vector", 32'(d), 32'h00);

        wr(3'd0, 8'h00, 8'hFF);

        // R2 R3 R6: every flag pattern against every enable pattern
        for (int p = 0; p < 32; p++) begin
            for (int e = 0; e < 32; e++) begin
                wr(3'd1, 8'(e), 8'hFF);
                wr(3'd2, 8'(p), 8'h1F);
                #1 chk("R6 irq", 32'(irq), 32'((p & e) != 0));
                rd(3'd3, d); chk("R2 vector", 32'(d), 32'(exp_vec(p & e)));
                rd(3'd2, d);
                chk("R3 flags after read", 32'(d),
                    32'(p) & ~((exp_vec(p & e) == 0) ? 32'h0 : (32'h1 << (exp_vec(p & e) / 2 - 1))));
            end
        end

        // R4: vector read races a receive event
        wr(3'd1, 8'h1F, 8'hFF);
        wr(3'd2, 8'h01, 8'h1F);
        reg_rd = 1'b1; reg_addr = 3'd3; rx_evt = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; rx_evt = 1'b0;
        chk("R4 vector", 32'(d), 32'h02);
        rd(3'd2, d); chk("R4 flag kept", 32'(d), 32'h01);

        // R5: masked writes against hardware sets
        wr(3'd2, 8'h1F, 8'h1F);
        wr(3'd2, 8'h00, 8'h05);
        rd(3'd2, d); chk("R5 partial mask", 32'(d), 32'h1A);
        wr(3'd2, 8'h00, 8'h1F);
        aux_evt = 3'b001;
        wr(3'd2, 8'h00, 8'h1F);
        aux_evt = '0;
        rd(3'd2, d); chk("R5 other bit set kept", 32'(d), 32'h04);
        wr(3'd2, 8'h01, 8'h1F);
        rx_evt = 1'b1;
        wr(3'd2, 8'h00, 8'h01);
        rx_evt = 1'b0;
        rd(3'd2, d); chk("R5 set beats clear", 32'(d), 32'h01);

        // R7 R8 R9: holding buffer, transmit enable off
        wr(3'd1, 8'h00, 8'hFF);
        wr(3'd2, 8'h02, 8'h1F);
        wr(3'd4, 8'hA5, 8'hFF);
        rd(3'd2, d); chk("R7 tx flag cleared", 32'(d), 32'h00);
        chk("R7 no load", 32'(sh_load), 0);
        wr(3'd4, 8'h3C, 8'hFF);
        rd(3'd5, d); chk("R9 overrun", 32'(d), 32'h01);
        sh_ready = 1'b1;
        #1 chk("R8 load strobe", 32'(sh_load), 1);
        chk("R9 byte kept", 32'(sh_data), 32'hA5);
        @(negedge clk);
        sh_ready = 1'b0;
        #1 chk("R8 single strobe", 32'(sh_load), 0);
        rd(3'd2, d); chk("R8 tx flag back", 32'(d), 32'h02);
        wr(3'd5, 8'h00, 8'h01);
        rd(3'd5, d); chk("R11 overrun cleared", 32'(d), 32'h00);

        // R11: error and break status
        err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
        rd(3'd5, d); chk("R11 error", 32'(d), 32'h02);
        brk_evt = 1'b1; @(negedge clk); brk_evt = 1'b0;
        rd(3'd5, d); chk("R11 break", 32'(d), 32'h06);
        wr(3'd5, 8'h00, 8'h02);
        rd(3'd5, d); chk("R11 masked clear", 32'(d), 32'h04);

        // R10: software reset with a byte held and events arriving
        wr(3'd1, 8'h1F, 8'hFF);
        wr(3'd2, 8'h1D, 8'h1F);
        wr(3'd4, 8'h11, 8'hFF);
        wr(3'd0, 8'h01, 8'hFF);
        rx_evt = 1'b1; @(negedge clk); rx_evt = 1'b0;
        rd(3'd2, d); chk("R10 flags", 32'(d), 32'h1E);
        rd(3'd1, d); chk("R10 enable", 32'(d), 32'h1C);
        rd(3'd5, d); chk("R10 status", 32'(d), 32'h00);
        sh_ready = 1'b1;
        #1 chk("R10 no load in reset", 32'(sh_load), 0);
        @(negedge clk);
        wr(3'd0, 8'h00, 8'hFF);
        #1 chk("R10 buffer emptied", 32'(sh_load), 0);
        @(negedge clk);
        sh_ready = 1'b0;
        rx_evt = 1'b1; @(negedge clk); rx_evt = 1'b0;
        rd(3'd2, d); chk("R10 events after release", 32'(d), 32'h1F);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule